// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block keeps the eight status bits of a serial port. Three kinds of logic reach it. The transmit and receive engines send one-cycle event pulses that set flags. The control register supplies the transmit-enable and clock-selection bits. Software reaches it through a simple register bus with one-cycle read and write strobes. The read data always shows the current register value. A read strobe tells the block that software has observed that value.

Software can only clear an error or data flag after it has seen that flag set. Every clear-only flag has its own arm latch. A read strobe that returns 1 for the flag arms the latch. The next write strobe uses the latch up, and a 0 in that bit position clears the flag only if the latch was armed. A flag that software never saw set therefore survives a blind write of 0. The block also decides whether the serial clock pin is driven as an output.

The register bus has no handshake. The bus strobes and the event pulses are plain single-cycle control signals that the block accepts on every clock edge. No valid/ready stream passes through the block, so it never applies back-pressure.

Top module: `sps_status_reg`

## Requirements
- R1: An asynchronous reset, or a high `stby_i` on a clock edge, loads the register with 0x84: bit 7 = 1, bit 2 = 1, all other bits 0. It also disarms every arm latch.
- R2: The bit positions of `bus_rdata_o`, from bit 7 down to bit 0, are: transmit-empty, receive-full, overrun, framing error, parity error, transmit-end, received multiprocessor bit, multiprocessor bit to send. `bus_rdata_o` shows the register as updated at the last clock edge.
- R3: A write strobe with a 0 in a clear-only bit (bits 7..3) leaves that flag set unless that bit's arm latch is armed.
- R4: A write strobe with a 1 in bits 7..3 never changes those flags.
- R5: A read strobe while a clear-only flag is 1 arms that flag's latch. The next write strobe with a 0 in that bit clears the flag. Any write strobe disarms latches that no read re-arms in the same cycle.
- R6: When a set event and a clearing write fall on the same clock edge, the flag ends up set.
- R7: Bit 7 is set by `tdr_xfer_i`. It is also set on the edge where `tx_en_i` is 0 after being 1 on the previous edge.
- R8: `rx_full_i` sets bit 6 and loads bit 1 from `rx_mpb_i`. `overrun_i`, `framing_i` and `parity_i` set bits 5, 4 and 3.
- R9: Bit 2 is set by `tend_set_i` and cleared by `tend_clr_i`; set wins if both arrive together. Writes never change bits 2 and 1.
- R10: Every write strobe loads bit 0 from `bus_wdata_i[0]`.
- R11: `sck_oe_o` is 1 only when `cke0_i` is 1, `sync_mode_i` is 0 and `ext_clk_i` is 0.
- R12: A flag that was 0 at the last read and became set before the write is not cleared by a 0 in that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_i | input | 1 | Standby entry, reloads reset value |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Current register value |
| tdr_xfer_i | input | 1 | Transmit data moved to shift register |
| tx_en_i | input | 1 | Transmit-enable control bit |
| tend_set_i | input | 1 | Transmission finished |
| tend_clr_i | input | 1 | Transmission started |
| rx_full_i | input | 1 | Received byte ready |
| rx_mpb_i | input | 1 | Multiprocessor bit of received frame |
| overrun_i | input | 1 | Overrun detected |
| framing_i | input | 1 | Framing error detected |
| parity_i | input | 1 | Parity error detected |
| cke0_i | input | 1 | Clock-output enable control bit |
| sync_mode_i | input | 1 | Synchronous mode selected |
| ext_clk_i | input | 1 | External clock selected |
| sck_oe_o | output | 1 | Serial clock pin driven as output |

## Verification
If an arm latch holds the wrong value, the effect shows on `bus_rdata_o` one clock after the next write strobe. Either a flag disappears although software never saw it set, or it stays set after a proper read-then-clear. A lost set event shows on the cycle after the pulse, as a 0 where a 1 is expected. A missed edge on `tx_en_i` shows as bit 7 staying 0. Standby and reset faults show at once as a value other than 0x84. A latch left armed through standby shows only on the first write of 0 that follows.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int REG_W = 8;
  localparam int CLR_LO = 3;
  localparam int CLR_HI = 7;
  localparam int NUM_CLR = CLR_HI - CLR_LO + 1;
  localparam logic [REG_W-1:0] RESET_VAL = 8'h84;
  localparam int B_TXE = 7;
  localparam int B_RXF = 6;
  localparam int B_OVR = 5;
  localparam int B_FRM = 4;
  localparam int B_PAR = 3;
  localparam int B_TEND = 2;
  localparam int B_MPB = 1;
  localparam int B_MPBT = 0;
endpackage

// File: rtl/sps_clr_flag.sv
module sps_clr_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stby_i,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wd_i,
  output logic flag_o
);
  logic flag_q, armed_q, clr_ok;

  // clearing needs an armed latch and a 0 in the written bit
  assign clr_ok = wr_i & ~wd_i & armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= RST_VAL;
      armed_q <= 1'b0;
    end else if (stby_i) begin
      flag_q  <= RST_VAL;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= set_i | (flag_q & ~clr_ok);
      armed_q <= (rd_i & flag_q) | (armed_q & ~wr_i);
    end
  end

  assign flag_o = flag_q;

  assert_clr_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !armed_q && !stby_i) |=> flag_q);
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !stby_i) |=> flag_q);
  assert_read_arms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && flag_q && !stby_i) |=> armed_q);
  assert_write_one_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wd_i && flag_q && !stby_i) |=> flag_q);
endmodule

// File: rtl/sps_ro_bits.sv
module sps_ro_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic stby_i,
  input  logic tend_set_i,
  input  logic tend_clr_i,
  input  logic rx_full_i,
  input  logic rx_mpb_i,
  input  logic wr_i,
  input  logic wd0_i,
  output logic [2:0] bits_o
);
  import sps_pkg::*;
  logic tend_q, mpb_q, mpbt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tend_q <= RESET_VAL[B_TEND];
      mpb_q  <= RESET_VAL[B_MPB];
      mpbt_q <= RESET_VAL[B_MPBT];
    end else if (stby_i) begin
      tend_q <= RESET_VAL[B_TEND];
      mpb_q  <= RESET_VAL[B_MPB];
      mpbt_q <= RESET_VAL[B_MPBT];
    end else begin
      if (tend_set_i)      tend_q <= 1'b1;
      else if (tend_clr_i) tend_q <= 1'b0;
      if (rx_full_i) mpb_q <= rx_mpb_i;
      if (wr_i)      mpbt_q <= wd0_i;
    end
  end

  assign bits_o = {tend_q, mpb_q, mpbt_q};

  assert_tend_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tend_set_i && !stby_i) |=> tend_q);
  assert_mpbt_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !stby_i) |=> (mpbt_q == $past(wd0_i)));
endmodule

// File: rtl/sps_sck_ctl.sv
module sps_sck_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cke0_i,
  input  logic sync_mode_i,
  input  logic ext_clk_i,
  output logic sck_oe_o
);
  // pin drives only with internal clock in asynchronous mode
  assign sck_oe_o = cke0_i & ~(sync_mode_i | ext_clk_i);

  assert_sck_sync_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode_i || ext_clk_i || !cke0_i) |-> !sck_oe_o);
endmodule

// File: rtl/sps_status_reg.sv
module sps_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby_i,
  input  logic       bus_rd_i,
  input  logic       bus_wr_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  input  logic       tdr_xfer_i,
  input  logic       tx_en_i,
  input  logic       tend_set_i,
  input  logic       tend_clr_i,
  input  logic       rx_full_i,
  input  logic       rx_mpb_i,
  input  logic       overrun_i,
  input  logic       framing_i,
  input  logic       parity_i,
  input  logic       cke0_i,
  input  logic       sync_mode_i,
  input  logic       ext_clk_i,
  output logic       sck_oe_o
);
  import sps_pkg::*;

  logic txen_q, txen_fall;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] reg_val;
  logic [2:0] ro_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txen_q <= 1'b0;
    else        txen_q <= tx_en_i;
  end
  assign txen_fall = txen_q & ~tx_en_i;

  always_comb begin
    set_vec        = '0;
    set_vec[B_TXE] = tdr_xfer_i | txen_fall;
    set_vec[B_RXF] = rx_full_i;
    set_vec[B_OVR] = overrun_i;
    set_vec[B_FRM] = framing_i;
    set_vec[B_PAR] = parity_i;
  end

  for (genvar i = CLR_LO; i <= CLR_HI; i++) begin : g_flag
    sps_clr_flag #(.RST_VAL(RESET_VAL[i])) u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .stby_i (stby_i),
      .set_i  (set_vec[i]),
      .rd_i   (bus_rd_i),
      .wr_i   (bus_wr_i),
      .wd_i   (bus_wdata_i[i]),
      .flag_o (reg_val[i])
    );
  end

  sps_ro_bits u_ro (
    .clk        (clk),
    .rst_n      (rst_n),
    .stby_i     (stby_i),
    .tend_set_i (tend_set_i),
    .tend_clr_i (tend_clr_i),
    .rx_full_i  (rx_full_i),
    .rx_mpb_i   (rx_mpb_i),
    .wr_i       (bus_wr_i),
    .wd0_i      (bus_wdata_i[0]),
    .bits_o     (ro_bits)
  );
  assign reg_val[B_TEND:B_MPBT] = ro_bits;

  sps_sck_ctl u_sck (
    .clk         (clk),
    .rst_n       (rst_n),
    .cke0_i      (cke0_i),
    .sync_mode_i (sync_mode_i),
    .ext_clk_i   (ext_clk_i),
    .sck_oe_o    (sck_oe_o)
  );

  assign bus_rdata_o = reg_val;

  assert_standby_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stby_i |=> (bus_rdata_o == RESET_VAL));
  assert_txen_fall_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_en_i) && !stby_i) |=> bus_rdata_o[B_TXE]);
  assert_ro_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby_i && !tend_set_i && !tend_clr_i && !rx_full_i) |=> $stable(bus_rdata_o[B_TEND:B_MPB]));
endmodule

// File: tb/sps_status_reg_tb.sv
module sps_status_reg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stby, rd, wr, xfer, txen, tset, tclr, rxf, rmpb, ovr, frm, par, cke, syn, ext;
  logic [7:0] wd;
  logic [7:0] rdata;
  logic sck_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_v;
  logic [7:3] exp_arm;
  logic exp_txprev;

  always #2 clk = ~clk;

  sps_status_reg dut_i (
    .clk(clk), .rst_n(rst_n), .stby_i(stby), .bus_rd_i(rd), .bus_wr_i(wr),
    .bus_wdata_i(wd), .bus_rdata_o(rdata), .tdr_xfer_i(xfer), .tx_en_i(txen),
    .tend_set_i(tset), .tend_clr_i(tclr), .rx_full_i(rxf), .rx_mpb_i(rmpb),
    .overrun_i(ovr), .framing_i(frm), .parity_i(par), .cke0_i(cke),
    .sync_mode_i(syn), .ext_clk_i(ext), .sck_oe_o(sck_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic idle();
    stby = 0; rd = 0; wr = 0; wd = 8'h00; xfer = 0; tset = 0; tclr = 0;
    rxf = 0; rmpb = 0; ovr = 0; frm = 0; par = 0;
  endtask

  // one clock: model next state from the requirements, then compare (R2)
  task automatic tick();
    logic [7:0] n;
    logic [7:3] na;
    logic [7:3] s;
    s = {xfer | (exp_txprev & ~txen), rxf, ovr, frm, par};
    if (stby) begin
      n = 8'h84; na = '0;
    end else begin
      for (int i = 3; i <= 7; i++) begin
        n[i]  = s[i] | (exp_v[i] & ~(wr & ~wd[i] & exp_arm[i]));
        na[i] = (rd & exp_v[i]) | (exp_arm[i] & ~wr);
      end
      n[2] = tset ? 1'b1 : (tclr ? 1'b0 : exp_v[2]);
      n[1] = rxf ? rmpb : exp_v[1];
      n[0] = wr ? wd[0] : exp_v[0];
    end
    exp_txprev = txen;
    @(posedge clk);
    @(negedge clk);
    exp_v = n; exp_arm = na;
    check("R2 model", rdata, exp_v);
    idle();
  endtask

  task automatic do_rd(); rd = 1; tick(); endtask
  task automatic do_wr(input logic [7:0] d); wr = 1; wd = d; tick(); endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(); txen = 0; cke = 0; syn = 0; ext = 0;
    exp_v = 8'h84; exp_arm = '0; exp_txprev = 0;
    #7;
    check("R1 reset value", rdata, 8'h84);
    @(negedge clk); rst_n = 1;
    tick();
    check("R1 after reset", rdata, 8'h84);

    // R3: blind write of 0 keeps receive-full
    rxf = 1; rmpb = 1; tick();
    check("R8 rxf and mpb", rdata & 8'h42, 8'h42);
    do_wr(8'h00);
    check("R3 blind clear ignored", rdata[6], 1'b1);
    // R4: write 1 after arming changes nothing, and uses up the latch
    do_rd(); do_wr(8'hFF);
    check("R4 write one keeps", rdata[6], 1'b1);
    check("R10 mpbt written 1", rdata[0], 1'b1);
    do_wr(8'h00);
    check("R5 latch consumed", rdata[6], 1'b1);
    // R5: proper sequence clears
    do_rd(); do_wr(8'hBF);
    check("R5 read then clear", rdata[6], 1'b0);
    check("R10 mpbt follows write", rdata[0], 1'b1);
    // R6: set and clear on the same edge
    rxf = 1; tick(); do_rd();
    wr = 1; wd = 8'h00; rxf = 1; tick();
    check("R6 set wins", rdata[6], 1'b1);
    do_rd(); do_wr(8'h00);
    check("R5 cleared again", rdata[6], 1'b0);
    // R12: read while 0, then set, then write 0
    do_rd(); rxf = 1; tick(); do_wr(8'h00);
    check("R12 late set survives", rdata[6], 1'b1);
    // R7: clear transmit-empty, then drop tx enable
    do_rd(); do_wr(8'h7F);
    check("R5 txe cleared", rdata[7], 1'b0);
    txen = 1; tick(); tick();
    check("R7 txe still clear", rdata[7], 1'b0);
    txen = 0; tick();
    check("R7 txen fall sets txe", rdata[7], 1'b1);
    do_rd(); do_wr(8'h7F); xfer = 1; tick();
    check("R7 transfer sets txe", rdata[7], 1'b1);
    // R9 transmit end
    tclr = 1; tick();
    check("R9 tend cleared", rdata[2], 1'b0);
    do_wr(8'hFF);
    check("R9 write ignored", rdata[2:1], 2'b00);
    tset = 1; tclr = 1; tick();
    check("R9 set wins", rdata[2], 1'b1);
    // R8 errors
    ovr = 1; frm = 1; par = 1; rxf = 1; rmpb = 0; tick();
    check("R8 error flags", rdata & 8'h7A, 8'h78);
    // R1 standby disarms
    do_rd(); stby = 1; tick();
    check("R1 standby value", rdata, 8'h84);
    rxf = 1; tick(); do_wr(8'h00);
    check("R1 latch disarmed", rdata[6], 1'b1);
    // R11 clock pin
    for (int k = 0; k < 8; k++) begin
      cke = k[0]; syn = k[1]; ext = k[2];
      #1;
      check("R11 sck enable", {7'd0, sck_oe}, {7'd0, (k == 1)});
    end
    // random phase with fixed seed
    void'($urandom(1234));
    for (int c = 0; c < 3000; c++) begin
      rd   = ($urandom % 4) == 0;
      wr   = ($urandom % 4) == 0;
      wd   = 8'($urandom);
      xfer = ($urandom % 8) == 0;
      tset = ($urandom % 8) == 0;
      tclr = ($urandom % 8) == 0;
      rxf  = ($urandom % 8) == 0;
      rmpb = 1'($urandom);
      ovr  = ($urandom % 10) == 0;
      frm  = ($urandom % 10) == 0;
      par  = ($urandom % 10) == 0;
      stby = ($urandom % 200) == 0;
      if (($urandom % 16) == 0) txen = ~txen;
      tick();
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule